// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This engine moves bytes between a small set of firmware configuration items and system memory without the processor copying them one at a time. Software builds a 16-byte descriptor in memory and then writes the descriptor's address to the engine's trigger port. The address can be written as a single 32-bit low half, or as a high half followed by a low half. The engine reads the descriptor over a word-wide memory master port and decodes its big-endian fields. These are a control word, a byte count and a 64-bit buffer address. It can optionally switch to another item, and then it copies item bytes out to the buffer, copies buffer bytes into the item, or moves the item offset forward.

When the operation is complete, the engine writes the control word back to the descriptor. A zero value means success. The error bit means a rejected write. While it works, the engine holds a busy flag and ignores further trigger writes. The item storage, the current selector key and the current byte offset all live inside the engine and persist from one descriptor to the next.

Top module: `cfgdma_engine`

## Requirements
- R1: A trigger write with `trigHigh`=1 stores the upper 32 address bits. A trigger write with `trigHigh`=0 starts the engine with descriptor address {stored upper half, `trigData`}, with bits 1:0 taken as zero. Each start clears the stored upper half, so a lone low write uses zero upper bits.
- R2: The descriptor is fetched as four word reads at offsets 0, 4, 8 and 12. Inside a memory word, the byte at address+j is on bits 8j+7:8j. Each field is big-endian, with the lowest-addressed byte most significant. The fields are: control at offset 0, length at 4, buffer address high word at 8 and low word at 12.
- R3: The control bits are bit 1 read, bit 2 skip, bit 3 select and bit 4 write. When several are set, read wins over write, and write wins over skip.
- R4: With the select bit set, control bits 31:16 become the current key and the offset returns to 0. This happens before any transfer.
- R5: A read copies length bytes, starting at the current offset, to the word-aligned buffer address. Bytes past the item end are written as zero. Byte enables cover only the length bytes, so the other buffer bytes are unchanged. The offset then advances by length.
- R6: A write, meaning the write bit set and the read bit clear, copies length bytes from the buffer into the item at the offset, and the offset advances by length.
- R7: A write with offset+length larger than the item size, or a write to a read-only item, changes no item byte and sets the error bit.
- R8: A skip, meaning neither read nor write is set, advances the offset by length and touches no memory.
- R9: Completion is one full-word write to the descriptor address. The value is 0 on success, or big-endian 1 (memory word 0x01000000) on error. `busy` drops in the cycle after that write is acknowledged.
- R10: Trigger writes of either half are ignored while `busy` is high.
- R11: Item k (k < ITEM_COUNT) holds ITEM_BYTES>>k bytes and is writable only when k is odd. Its initial byte i is 0x40 + k*ITEM_BYTES + i. Any other key is an item of size 0, which reads as zeros.
- R12: A memory request keeps its address and direction stable until `memAck`.
- R13: After reset, `busy` and `memReq` are low, and the key and offset are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigWrEn | input | 1 | Trigger address write strobe |
| trigHigh | input | 1 | 1: write upper address half; 0: write lower half and start |
| trigData | input | 32 | Trigger address half |
| busy | output | 1 | Engine active |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | 1: memory write, 0: memory read |
| memAddr | output | 64 | Word-aligned byte address |
| memBe | output | 4 | Byte lane enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Completes the current request |

## Verification
The hardest case to reach is a write that is refused for bounds after an earlier descriptor has already moved the offset. The check depends on state left behind by previous operations, not on the descriptor alone. The stimulus table therefore chains descriptors on the same item: it selects the item, skips part of it, tries a write that overruns the end, and then writes a length that ends exactly at the last byte. A read-back at the end proves that the rejected write left the item untouched. Trigger writes issued in the middle of a run cover the case where a busy engine must ignore them.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

  localparam int CTL_ERR    = 0;
  localparam int CTL_READ   = 1;
  localparam int CTL_SKIP   = 2;
  localparam int CTL_SELECT = 3;
  localparam int CTL_WRITE  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_PLAN, ST_READ, ST_WRITE, ST_BACK
  } dmaState_e;

  typedef enum logic [1:0] {
    AM_DESC, AM_BUF, AM_BACK
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      start;
    logic      capture;
    logic [1:0] wordIdx;
    logic      load;
    logic      skip;
    logic      stepRead;
    logic      stepWrite;
    logic      flagErr;
    addrMode_e addrMode;
  } dmaStrobe_t;

  // decoded state from datapath to control
  typedef struct packed {
    logic opRead;
    logic opWrite;
    logic opSkip;
    logic lenZero;
    logic lastChunk;
    logic writeBad;
  } dmaStatus_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/cfgdma_items.sv
module cfgdma_items #(
  parameter int ITEM_COUNT = 4,
  parameter int ITEM_BYTES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] key,
  input  logic [31:0] offset,
  input  logic [3:0]  wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdWord,
  output logic [31:0] itemSize,
  output logic        itemWritable
);
  localparam int TOTAL = ITEM_COUNT * ITEM_BYTES;
  localparam int IDXW  = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic [7:0]      store [TOTAL];
  logic            keyValid;
  logic [31:0]     baseIdx;
  logic [3:0]      inRange;
  logic [IDXW-1:0] laneIdx [4];

  always_comb begin
    keyValid     = 32'(key) < 32'(ITEM_COUNT);
    itemSize     = keyValid ? (32'(ITEM_BYTES) >> key) : 32'd0;
    itemWritable = keyValid && key[0];
    baseIdx      = keyValid ? (32'(key) * 32'(ITEM_BYTES)) : 32'd0;
  end

  generate
    for (genvar j = 0; j < 4; j++) begin : g_lane
      logic [32:0] pos;
      logic [31:0] flat;
      assign pos          = {1'b0, offset} + 33'(j);
      assign inRange[j]   = pos < {1'b0, itemSize};
      assign flat         = baseIdx + offset + 32'(j);
      assign laneIdx[j]   = flat[IDXW-1:0];
      assign rdWord[8*j +: 8] = inRange[j] ? store[laneIdx[j]] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) store[i] <= 8'(32'h40 + i);
    end else begin
      for (int j = 0; j < 4; j++)
        if (wrEn[j] && inRange[j]) store[laneIdx[j]] <= wrData[8*j +: 8];
    end
  end

  // R7: a lane is never written outside the selected item
  p_lane_in_item_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn != 4'b0) |-> (itemWritable && itemSize != 32'd0));

endmodule

// File: rtl/cfgdma_ctrl.sv
module cfgdma_ctrl
  import cfgdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigLow,
  input  logic       memAck,
  input  dmaStatus_t status,
  output dmaStrobe_t stb,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy
);
  dmaState_e state, nxt;
  logic [1:0] fetchIdx;

  always_comb begin
    stb          = '0;
    stb.addrMode = AM_DESC;
    stb.wordIdx  = fetchIdx;
    memReq       = 1'b0;
    memWrite     = 1'b0;
    nxt          = state;
    case (state)
      ST_IDLE: if (trigLow) begin
        stb.start = 1'b1;
        nxt       = ST_FETCH;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.capture = 1'b1;
          if (fetchIdx == 2'd3) nxt = ST_LOAD;
        end
      end
      ST_LOAD: begin
        stb.load = 1'b1;
        nxt      = ST_PLAN;
      end
      ST_PLAN: begin
        if (status.opRead) begin
          nxt = status.lenZero ? ST_BACK : ST_READ;
        end else if (status.opWrite) begin
          if (status.writeBad) begin
            stb.flagErr = 1'b1;
            nxt         = ST_BACK;
          end else begin
            nxt = status.lenZero ? ST_BACK : ST_WRITE;
          end
        end else begin
          stb.skip = status.opSkip;
          nxt      = ST_BACK;
        end
      end
      ST_READ: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        stb.addrMode = AM_BUF;
        if (memAck) begin
          stb.stepRead = 1'b1;
          if (status.lastChunk) nxt = ST_BACK;
        end
      end
      ST_WRITE: begin
        memReq       = 1'b1;
        stb.addrMode = AM_BUF;
        if (memAck) begin
          stb.stepWrite = 1'b1;
          if (status.lastChunk) nxt = ST_BACK;
        end
      end
      ST_BACK: begin
        memReq       = 1'b1;
        memWrite     = 1'b1;
        stb.addrMode = AM_BACK;
        if (memAck) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchIdx <= 2'd0;
    end else begin
      state <= nxt;
      if (stb.start)        fetchIdx <= 2'd0;
      else if (stb.capture) fetchIdx <= fetchIdx + 2'd1;
    end
  end

  assign busy = (state != ST_IDLE);

  // R2: the plan step is only reached after all four descriptor words
  p_plan_after_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && fetchIdx == 2'd3) |=> (state == ST_LOAD));

endmodule

// File: rtl/cfgdma_dp.sv
module cfgdma_dp
  import cfgdma_pkg::*;
#(
  parameter int ITEM_COUNT = 4,
  parameter int ITEM_BYTES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dmaStrobe_t  stb,
  input  logic        busy,
  input  logic        trigWrEn,
  input  logic        trigHigh,
  input  logic [31:0] trigData,
  input  logic [31:0] memRdata,
  output logic [63:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  output dmaStatus_t  status
);
  logic [31:0] hiHalf;
  logic [63:0] descBase;
  logic [31:0] descWord [4];
  logic [15:0] curKey;
  logic [31:0] curOff;
  logic [31:0] remain;
  logic [63:0] bufPtr;
  logic        errFlag;

  logic [31:0] ctlField, lenField;
  logic [63:0] bufField;
  logic [2:0]  chunk;
  logic [3:0]  laneMask;
  logic [31:0] itemWord, itemSize;
  logic        itemWritable;
  logic [63:0] endPos;

  assign ctlField = swapBytes(descWord[0]);
  assign lenField = swapBytes(descWord[1]);
  assign bufField = {swapBytes(descWord[2]), swapBytes(descWord[3])};

  assign chunk = (remain >= 32'd4) ? 3'd4 : remain[2:0];
  generate
    for (genvar j = 0; j < 4; j++) begin : g_mask
      assign laneMask[j] = 3'(j) < chunk;
    end
  endgenerate

  cfgdma_items #(.ITEM_COUNT(ITEM_COUNT), .ITEM_BYTES(ITEM_BYTES)) items_i (
    .clk          (clk),
    .rstN         (rstN),
    .key          (curKey),
    .offset       (curOff),
    .wrEn         (stb.stepWrite ? laneMask : 4'b0),
    .wrData       (memRdata),
    .rdWord       (itemWord),
    .itemSize     (itemSize),
    .itemWritable (itemWritable)
  );

  assign endPos = {32'd0, curOff} + {32'd0, remain};

  always_comb begin
    status.opRead    = ctlField[CTL_READ];
    status.opWrite   = ctlField[CTL_WRITE];
    status.opSkip    = ctlField[CTL_SKIP];
    status.lenZero   = (remain == 32'd0);
    status.lastChunk = (remain <= 32'd4);
    status.writeBad  = !itemWritable || (endPos > {32'd0, itemSize});
  end

  always_comb begin
    case (stb.addrMode)
      AM_BUF:  memAddr = bufPtr;
      AM_BACK: memAddr = descBase;
      default: memAddr = descBase + {60'd0, stb.wordIdx, 2'b00};
    endcase
    memWdata = (stb.addrMode == AM_BACK) ? (errFlag ? swapBytes(32'd1) : 32'd0)
                                         : itemWord;
    memBe    = (stb.addrMode == AM_BUF) ? laneMask : 4'hF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiHalf   <= '0;
      descBase <= '0;
      for (int i = 0; i < 4; i++) descWord[i] <= '0;
      curKey   <= '0;
      curOff   <= '0;
      remain   <= '0;
      bufPtr   <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.start) begin
        descBase <= {hiHalf, trigData[31:2], 2'b00};
        hiHalf   <= '0;
        errFlag  <= 1'b0;
      end else if (trigWrEn && trigHigh && !busy) begin
        hiHalf <= trigData;
      end
      if (stb.capture) descWord[stb.wordIdx] <= memRdata;
      if (stb.load) begin
        remain <= lenField;
        bufPtr <= {bufField[63:2], 2'b00};
        if (ctlField[CTL_SELECT]) begin
          curKey <= ctlField[31:16];
          curOff <= '0;
        end
      end
      if (stb.skip) curOff <= curOff + remain;
      if (stb.stepRead || stb.stepWrite) begin
        curOff <= curOff + 32'(chunk);
        remain <= remain - 32'(chunk);
        bufPtr <= bufPtr + 64'd4;
      end
      if (stb.flagErr) errFlag <= 1'b1;
    end
  end

  // R3 / R7: item bytes are stored only for an accepted, non-read write
  p_write_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWrite |-> (status.opWrite && !status.opRead && !errFlag));

  // R10: the descriptor address holds for the whole run
  p_desc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(descBase));

  // R5: buffer lane enables are a contiguous run from lane 0
  p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stb.addrMode == AM_BUF) |->
      (memBe == 4'h1 || memBe == 4'h3 || memBe == 4'h7 || memBe == 4'hF));

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int ITEM_COUNT = 4,
  parameter int ITEM_BYTES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigWrEn,
  input  logic        trigHigh,
  input  logic [31:0] trigData,
  output logic        busy,
  output logic        memReq,
  output logic        memWrite,
  output logic [63:0] memAddr,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  input  logic        memAck
);
  dmaStrobe_t stb;
  dmaStatus_t status;

  cfgdma_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .trigLow  (trigWrEn && !trigHigh),
    .memAck   (memAck),
    .status   (status),
    .stb      (stb),
    .memReq   (memReq),
    .memWrite (memWrite),
    .busy     (busy)
  );

  cfgdma_dp #(.ITEM_COUNT(ITEM_COUNT), .ITEM_BYTES(ITEM_BYTES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busy     (busy),
    .trigWrEn (trigWrEn),
    .trigHigh (trigHigh),
    .trigData (trigData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memBe    (memBe),
    .status   (status)
  );

  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  p_back_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && stb.addrMode == AM_BACK) |->
      (memWrite && memBe == 4'hF && (memWdata == 32'h0 || memWdata == 32'h0100_0000)));

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memAck && memWrite && memBe == 4'hF));

  p_reset_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !memReq));

endmodule

// File: tb/cfgdma_engine_tb.sv
module cfgdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigWrEn = 1'b0, trigHigh = 1'b0;
  logic [31:0] trigData = '0;
  logic        busy, memReq, memWrite, memAck;
  logic [63:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata, memRdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfgdma_engine dut_i (
    .clk(clk), .rstN(rstN), .trigWrEn(trigWrEn), .trigHigh(trigHigh),
    .trigData(trigData), .busy(busy), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck));

  // memory model: 1 KiB, aliased, ack one cycle after request
  logic [31:0] mem [256];
  logic        ackR;
  logic [63:0] reqLog [16];
  int          logCnt;
  logic        logClr = 1'b0;
  logic        pend;
  logic [63:0] pendAddr;
  logic        pendWe;
  int          stableViol = 0;

  assign memAck   = ackR;
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      ackR <= 1'b0; pend <= 1'b0; logCnt <= 0;
    end else begin
      ackR <= memReq && !ackR;
      if (memReq && ackR && memWrite)
        for (int j = 0; j < 4; j++)
          if (memBe[j]) mem[memAddr[9:2]][8*j +: 8] <= memWdata[8*j +: 8];
      if (pend && (!memReq || memAddr != pendAddr || memWrite != pendWe))
        stableViol <= stableViol + 1;
      pend <= memReq && !ackR; pendAddr <= memAddr; pendWe <= memWrite;
      if (logClr) logCnt <= 0;
      else if (memReq && ackR && logCnt < 16) begin
        reqLog[logCnt] <= memAddr; logCnt <= logCnt + 1;
      end
    end
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'(8'h80 + v * 7 + i);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic trig(input logic hi, input logic [31:0] d);
    @(negedge clk); trigWrEn = 1'b1; trigHigh = hi; trigData = d;
    @(negedge clk); trigWrEn = 1'b0; trigHigh = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({tag, " timeout"}, 64'd1, 64'd0);
  endtask

  task automatic clearLog();
    @(negedge clk); logClr = 1'b1; @(negedge clk); logClr = 1'b0;
  endtask

  task automatic putDesc(input int base, input logic [31:0] ctl, input logic [31:0] len,
                         input logic [63:0] addr);
    mem[base/4]     = bsw(ctl);
    mem[base/4 + 1] = bsw(len);
    mem[base/4 + 2] = bsw(addr[63:32]);
    mem[base/4 + 3] = bsw(addr[31:0]);
  endtask

  // {control[4:0], key, length}; bits: 1 read, 2 skip, 3 select, 4 write
  localparam int NV = 22;
  localparam logic [36:0] VEC [NV] = '{
    {5'h02, 16'd0, 16'd2},  // R13 start state key 0 offset 0
    {5'h0A, 16'd0, 16'd6},  // R4 select resets offset
    {5'h02, 16'd0, 16'd5},  // R5 continue
    {5'h02, 16'd0, 16'd8},  // R5 run past end
    {5'h18, 16'd1, 16'd3},  // R6 write
    {5'h0A, 16'd1, 16'd8},
    {5'h18, 16'd2, 16'd2},  // R7 read-only
    {5'h0C, 16'd3, 16'd1},  // R8 skip
    {5'h10, 16'd3, 16'd2},  // R7 overrun
    {5'h10, 16'd3, 16'd1},  // R7 exact fit
    {5'h0A, 16'd3, 16'd2},
    {5'h1E, 16'd1, 16'd4},  // R3 read wins
    {5'h1C, 16'd1, 16'd8},  // R3 write beats skip
    {5'h0A, 16'd1, 16'd8},
    {5'h0A, 16'd9, 16'd4},  // R11 absent item
    {5'h0A, 16'd0, 16'd0},  // zero length
    {5'h0C, 16'd1, 16'd3},
    {5'h10, 16'd1, 16'd6},  // R7 end beyond item
    {5'h10, 16'd1, 16'd5},
    {5'h0A, 16'd1, 16'd8},
    {5'h08, 16'd2, 16'd0},  // select only
    {5'h02, 16'd2, 16'd4}
  };

  logic [7:0] model [4][16];
  int msel, moff;

  function automatic int isz(input int k);
    return (k >= 0 && k < 4) ? (16 >> k) : 0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] expBuf [12];
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) model[k][i] = 8'(8'h40 + k * 16 + i);
    msel = 0; moff = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 busy after reset", {63'd0, busy}, 64'd0);
    chk("R13 memReq after reset", {63'd0, memReq}, 64'd0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      logic [4:0]  c;
      int          key, len;
      bit          expErr;
      c = VEC[v][36:32]; key = int'(VEC[v][31:16]); len = int'(VEC[v][15:0]);
      for (int i = 0; i < 12; i++) begin
        expBuf[i] = pat(v, i);
        mem[(32'h200 + i) / 4][8*(i%4) +: 8] = pat(v, i);
      end
      putDesc(32'h100, {VEC[v][31:16], 11'd0, c}, 32'(len), 64'h200);
      expErr = 0;
      if (c[3]) begin msel = key; moff = 0; end
      if (c[1]) begin
        for (int i = 0; i < len; i++)
          expBuf[i] = (moff + i < isz(msel)) ? model[msel][moff + i] : 8'h00;
        moff += len;
      end else if (c[4]) begin
        if (!(msel < 4 && msel % 2 == 1) || moff + len > isz(msel)) expErr = 1;
        else begin
          for (int i = 0; i < len; i++) model[msel][moff + i] = pat(v, i);
          moff += len;
        end
      end else if (c[2]) moff += len;
      trig(1'b0, 32'h100);
      waitIdle("R9 table");
      chk($sformatf("R9 control result vec %0d", v), {32'd0, bsw(mem[32'h100/4])},
          {63'd0, expErr});
      for (int i = 0; i < 12; i++)
        chk($sformatf("R5/R6/R7/R8/R11 buffer byte %0d vec %0d", i, v),
            {56'd0, mem[(32'h200 + i) / 4][8*(i%4) +: 8]}, {56'd0, expBuf[i]});
    end

    // R1 R2: split trigger, fetch order and write-back address
    putDesc(32'h100, 32'h0, 32'h0, 64'h200);
    clearLog();
    trig(1'b1, 32'h3);
    trig(1'b0, 32'h100);
    waitIdle("R1 split");
    chk("R1 first fetch address", reqLog[0], 64'h3_0000_0100);
    chk("R2 second fetch address", reqLog[1], 64'h3_0000_0104);
    chk("R2 fourth fetch address", reqLog[3], 64'h3_0000_010C);
    chk("R9 write-back address", reqLog[4], 64'h3_0000_0100);
    chk("R8 no-op request count", 64'(logCnt), 64'd5);
    clearLog();
    trig(1'b0, 32'h100);
    waitIdle("R1 low only");
    chk("R1 upper half cleared", reqLog[0], 64'h100);

    // R10: triggers while busy are ignored
    putDesc(32'h100, 32'h000A, 32'd8, 64'h200);
    putDesc(32'h180, 32'h0002, 32'd4, 64'h240);
    trig(1'b0, 32'h100);
    trig(1'b0, 32'h180);
    trig(1'b1, 32'h5);
    waitIdle("R10");
    repeat (10) @(negedge clk);
    chk("R10 busy stays low", {63'd0, busy}, 64'd0);
    chk("R10 second descriptor untouched", {32'd0, mem[32'h180/4]}, {32'd0, bsw(32'h2)});
    clearLog();
    trig(1'b0, 32'h100);
    waitIdle("R10 hi ignored");
    chk("R10 upper half write ignored", reqLog[0], 64'h100);

    chk("R12 request stability", 64'(stableViol), 64'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule